// File: doc/BRIEF.md
# Doorbell Signalling Unit

This block gives software and bus-mastering devices a way to raise an interrupt on one or more processors with a single posted write. A global trigger port takes one 32-bit word. The word names a doorbell (0 to 31) in its low five bits and a one-hot map of target processors starting at bit 8. For every processor whose map bit is set, the unit latches that doorbell into the processor's 32-bit pending register. A device that sends a message-signalled interrupt writes the same port. Its data word is the target processor bit at position 8+cpu, ORed with 16 plus its vector number.

Each processor has a private pending register and a private enable register, both 32 bits wide. They are written through a per-processor register port. Writing 0 to a pending bit clears it and writing 1 leaves it alone, so one bit is cleared by writing its complement. The enable register is plain read/write. Doorbells 0–7 form the inter-processor group and doorbells 16–31 form the message group. For each processor, the enabled pending bits of each group are ORed into one request line that feeds the downstream interrupt controller. Doorbells 8–15 are stored but drive neither request line.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset, every pending bit, every enable bit and both request lines of every processor are 0.
- R2: A trigger write with index i = data[4:0] sets pending bit i of each processor c whose bit data[8+c] is 1. The bit is visible after the next clock edge. Processors whose map bit is 0 are unchanged.
- R3: A trigger write whose processor map data[8+NCPU-1:8] is all zero changes no pending bit.
- R4: A pending-register write (reg_sel=0) to processor reg_cpu clears every pending bit where reg_data is 0 and keeps every bit where reg_data is 1.
- R5: An enable-register write (reg_sel=1) loads reg_data into the addressed processor's enable register, which reads back unchanged.
- R6: ipi_req[c] is 1 exactly when some bit 0–7 is both pending and enabled for processor c (group mask 0x000000FF).
- R7: msi_req[c] is 1 exactly when some bit 16–31 is both pending and enabled for processor c (group mask 0xFFFF0000).
- R8: Doorbells 8–15 are latched into the pending register and read back, but never drive ipi_req or msi_req.
- R9: If a trigger sets a pending bit in the same cycle as a pending-register write that clears it, the bit ends up set.
- R10: Pending and enable writes through the register port affect only the processor selected by reg_cpu.
- R11: A message write with data (1<<(8+c)) | (16+v), v in 0..15, sets pending bit 16+v of processor c only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Trigger write strobe |
| trig_data | input | 32 | Trigger word: index in [4:0], processor map from bit 8 |
| reg_wr | input | 1 | Per-processor register write strobe |
| reg_sel | input | 1 | 0 selects the pending register, 1 the enable register |
| reg_cpu | input | CPU_W | Processor addressed by the register write |
| reg_data | input | 32 | Register write data |
| rd_cpu | input | CPU_W | Processor whose registers are read back |
| rd_pend | output | 32 | Pending register of rd_cpu |
| rd_en | output | 32 | Enable register of rd_cpu |
| ipi_req | output | NCPU | Inter-processor group request, one per processor |
| msi_req | output | NCPU | Message group request, one per processor |

## Verification
On every cycle the assertions check that a trigger lands in each targeted processor and that an empty map leaves all pending state untouched. They also check that a pending write leaves no zero-data bit set unless a trigger hit it, that enable writes load exactly, and that bits 8–15 alone never raise a request. Group isolation across all 32 indices, every processor map, and the interaction of enable patterns with both groups can only be shown by the bench sweeps against an arithmetic model. The same goes for the per-processor isolation of register writes and the message-format data encoding.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_NUM   = 32;
  localparam int DB_IDX_W = 5;
  localparam int MAP_LSB  = 8;
  localparam logic [DB_NUM-1:0] IPI_GRP = 32'h0000_00FF;
  localparam logic [DB_NUM-1:0] MSI_GRP = 32'hFFFF_0000;

  // one-hot doorbell vector from an index
  function automatic logic [DB_NUM-1:0] db_onehot(input logic [DB_IDX_W-1:0] idx);
    return {{(DB_NUM-1){1'b0}}, 1'b1} << idx;
  endfunction

  // any bit of a group both pending and enabled
  function automatic logic grp_any(input logic [DB_NUM-1:0] pend,
                                   input logic [DB_NUM-1:0] en,
                                   input logic [DB_NUM-1:0] grp);
    return |(pend & en & grp);
  endfunction

  // pending update: clear-by-zero first, then set has priority
  function automatic logic [DB_NUM-1:0] pend_next(input logic [DB_NUM-1:0] cur,
                                                  input logic clr,
                                                  input logic [DB_NUM-1:0] keep,
                                                  input logic [DB_NUM-1:0] set);
    return (clr ? (cur & keep) : cur) | set;
  endfunction
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
  import db_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                           trig_valid,
  input  logic [DB_NUM-1:0]              trig_data,
  output logic [NCPU-1:0][DB_NUM-1:0]    set_vec
);
  logic [DB_NUM-1:0] hot;
  assign hot = db_onehot(trig_data[DB_IDX_W-1:0]);

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    assign set_vec[c] = (trig_valid && trig_data[MAP_LSB+c]) ? hot : '0;
  end
endmodule

// File: rtl/db_cpu_slice.sv
module db_cpu_slice
  import db_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DB_NUM-1:0] set_vec,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [DB_NUM-1:0] wdata,
  output logic [DB_NUM-1:0] pend_q,
  output logic [DB_NUM-1:0] en_q,
  output logic              ipi_req,
  output logic              msi_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_next(pend_q, clr_we, wdata, set_vec);
      if (en_we) en_q <= wdata;
    end
  end

  assign ipi_req = grp_any(pend_q, en_q, IPI_GRP);
  assign msi_req = grp_any(pend_q, en_q, MSI_GRP);
endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit
  import db_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [31:0]       trig_data,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [31:0]       reg_data,
  input  logic [CPU_W-1:0]  rd_cpu,
  output logic [31:0]       rd_pend,
  output logic [31:0]       rd_en,
  output logic [NCPU-1:0]   ipi_req,
  output logic [NCPU-1:0]   msi_req
);
  // named internal events, visible to the bound checker
  logic [NCPU-1:0][DB_NUM-1:0] set_all;
  logic [NCPU-1:0][DB_NUM-1:0] pend_all;
  logic [NCPU-1:0][DB_NUM-1:0] en_all;
  logic [NCPU-1:0]             clr_hit;
  logic [NCPU-1:0]             en_hit;

  db_trig_decode #(.NCPU(NCPU)) u_dec (
    .trig_valid (trig_valid),
    .trig_data  (trig_data),
    .set_vec    (set_all)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign clr_hit[c] = reg_wr && !reg_sel && (reg_cpu == CPU_W'(c));
    assign en_hit[c]  = reg_wr &&  reg_sel && (reg_cpu == CPU_W'(c));

    db_cpu_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_all[c]),
      .clr_we  (clr_hit[c]),
      .en_we   (en_hit[c]),
      .wdata   (reg_data),
      .pend_q  (pend_all[c]),
      .en_q    (en_all[c]),
      .ipi_req (ipi_req[c]),
      .msi_req (msi_req[c])
    );
  end

  assign rd_pend = pend_all[rd_cpu];
  assign rd_en   = en_all[rd_cpu];
endmodule

// File: rtl/db_doorbell_chk.sv
module db_doorbell_chk
  import db_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig_valid,
  input  logic [31:0]                 trig_data,
  input  logic                        reg_wr,
  input  logic                        reg_sel,
  input  logic [CPU_W-1:0]            reg_cpu,
  input  logic [31:0]                 reg_data,
  input  logic [NCPU-1:0][DB_NUM-1:0] pend_all,
  input  logic [NCPU-1:0][DB_NUM-1:0] en_all,
  input  logic [NCPU-1:0]             ipi_req,
  input  logic [NCPU-1:0]             msi_req
);
  localparam logic [DB_NUM-1:0] MID_GRP = ~(IPI_GRP | MSI_GRP);

  // R3
  empty_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_data[MAP_LSB +: NCPU] == '0 && !reg_wr) |=> $stable(pend_all));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R2 and R9: a targeted doorbell is set after the edge, clear or not
    trig_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_valid && trig_data[MAP_LSB+c])
      |=> pend_all[c][$past(trig_data[DB_IDX_W-1:0])]);

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && reg_cpu == CPU_W'(c) && !(trig_valid && trig_data[MAP_LSB+c]))
      |=> ((pend_all[c] & ~$past(reg_data)) == '0));

    // R5
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && reg_cpu == CPU_W'(c)) |=> en_all[c] == $past(reg_data));

    // R8
    mid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_all[c] & en_all[c] & ~MID_GRP) == '0) |-> (!ipi_req[c] && !msi_req[c]));
  end
endmodule

bind db_doorbell_unit db_doorbell_chk #(.NCPU(NCPU), .CPU_W(CPU_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_valid (trig_valid),
  .trig_data  (trig_data),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_cpu    (reg_cpu),
  .reg_data   (reg_data),
  .pend_all   (pend_all),
  .en_all     (en_all),
  .ipi_req    (ipi_req),
  .msi_req    (msi_req)
);

// File: tb/db_doorbell_unit_test.sv
module db_doorbell_unit_test;
  localparam int NCPU  = 4;
  localparam int CPU_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trig_valid = 1'b0;
  logic [31:0]      trig_data = '0;
  logic             reg_wr = 1'b0;
  logic             reg_sel = 1'b0;
  logic [CPU_W-1:0] reg_cpu = '0;
  logic [31:0]      reg_data = '0;
  logic [CPU_W-1:0] rd_cpu = '0;
  logic [31:0]      rd_pend, rd_en;
  logic [NCPU-1:0]  ipi_req, msi_req;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] m_pend [NCPU];
  logic [31:0] m_en   [NCPU];

  always #4 clk = ~clk;

  db_doorbell_unit #(.NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_data(trig_data),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_cpu(reg_cpu), .reg_data(reg_data),
    .rd_cpu(rd_cpu), .rd_pend(rd_pend), .rd_en(rd_en),
    .ipi_req(ipi_req), .msi_req(msi_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every processor against the model (R6, R7 computed arithmetically)
  task automatic compare_all(input string tag);
    for (int c = 0; c < NCPU; c++) begin
      rd_cpu = CPU_W'(c);
      #1;
      check(tag, rd_pend, m_pend[c]);
      check("R5", rd_en, m_en[c]);
      check("R6", {31'b0, ipi_req[c]}, {31'b0, ((m_pend[c] & m_en[c]) % 256) != 0});
      check("R7", {31'b0, msi_req[c]}, {31'b0, ((m_pend[c] & m_en[c]) >> 16) != 0});
    end
  endtask

  // update the model from the inputs now driven, clock once, compare
  task automatic step(input string tag);
    if (reg_wr) begin
      if (reg_sel) m_en[reg_cpu] = reg_data;
      else         m_pend[reg_cpu] = m_pend[reg_cpu] & reg_data;
    end
    if (trig_valid)
      for (int c = 0; c < NCPU; c++)
        if (trig_data[8+c]) m_pend[c] = m_pend[c] | (32'd1 << (trig_data % 32));
    @(posedge clk);
    #1;
    trig_valid = 1'b0;
    reg_wr = 1'b0;
    #1;
    compare_all(tag);
  endtask

  task automatic trig(input logic [31:0] d);
    trig_valid = 1'b1; trig_data = d;
  endtask

  task automatic regw(input logic sel, input int c, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_cpu = CPU_W'(c); reg_data = d;
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCPU; c++) begin
      regw(1'b0, c, 32'h0);
      step("R4");
    end
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_00FF;
    pats[2] = 32'hFFFF_0000; pats[3] = 32'h0000_FF00;
    for (int c = 0; c < NCPU; c++) begin m_pend[c] = '0; m_en[c] = '0; end

    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    compare_all("R1");
    check("R1", {28'b0, ipi_req | msi_req}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R2/R8 sweep: every index, every nonzero map, rotating enable patterns
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < NCPU; c++) begin
        regw(1'b1, c, pats[(i + c) % 4]);
        step("R5");
      end
      for (int m = 1; m < 16; m++) begin
        trig((m << 8) | i);
        step((i >= 8 && i < 16) ? "R8" : "R2");
        clear_all();
      end
    end

    // R5/R10: enable write to one processor only
    regw(1'b1, 2, 32'hA5A5_5A5A);
    step("R10");

    // R3: empty map, junk in other fields
    for (int i = 0; i < 32; i++) begin
      trig(32'hABC0_0000 | i);
      step("R3");
    end

    // R4: clear single bit by complement, other bits kept
    for (int c = 0; c < NCPU; c++) begin
      regw(1'b1, c, 32'hFFFF_FFFF);
      step("R5");
    end
    trig(32'h0000_0F03); step("R2");
    trig(32'h0000_0F15); step("R2");
    trig(32'h0000_0F0A); step("R8");
    regw(1'b0, 1, ~(32'd1 << 3));
    step("R4");
    regw(1'b0, 3, ~(32'd1 << 21));
    step("R10");

    // R9: set and clear of the same bit in one cycle
    regw(1'b0, 0, 32'h0);
    trig(32'h0000_0104);
    step("R9");
    check("R9", m_pend[0], 32'h0000_0010);
    clear_all();

    // R11: message-format writes
    for (int c = 0; c < NCPU; c++)
      for (int v = 0; v < 16; v++) begin
        trig((32'd1 << (8 + c)) | (16 + v));
        step("R11");
        clear_all();
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule